// File: doc/BRIEF.md
# Serial Line Control and Status Unit

This block holds the control and status for one channel of a terminal multiplexer. The host sends it output words. Each word carries a channel number, a character and a few control bits. When the channel number matches, the block loads the character into a transmit holding register and marks the line enabled. A fixed, parameterised busy interval stands in for serialisation time. When that interval ends, the character is presented on the line side.

On the receive side, a one-character holding register collects characters from the line. It tracks pending and overrun. The host reads that register through a read strobe, and the read clears both flags. The block also tracks line enable, transmit-interrupt enable, receiver enable, carrier and data-set-ready. It answers skip tests and raises single-cycle receive, transmit, carrier-on and carrier-off events for an external scanner.

A mode input selects between two host conventions. They differ in how one control bit is read. In mode A the bit enables the line when set and disables it when clear. In mode B, a set bit is a hang-up command (clear DTR), and modem signals and the skip test are used. The modem and the network connection are outside the block. A `link_up` level and a character strobe model them.

Top module: `line_ctl_unit`

## Requirements
- R1: After a synchronous active-low reset, line enable, transmit-interrupt enable, carrier, DSR, pending, overrun, busy and all event outputs are 0.
- R2: A host write whose channel field (bits 4:0) differs from the LINE_ID parameter changes no state and starts no transmission.
- R3: An enabling write sets line enable and the receiver. It copies bit 14 into transmit-interrupt enable. When bit 15 is clear, it stores bits 23:16 as the transmit character. If the transmitter is idle, `tx_busy` then rises for exactly TX_CYCLES cycles. A write made while busy replaces the character without restarting the interval.
- R4: In the cycle `tx_busy` falls, `tx_out_valid` pulses with the held character if `link_up` is high. `evt_tx` pulses only if transmit-interrupt enable is set.
- R5: A character accepted while `link_up` is high and the receiver is enabled is stored and raises `evt_rx`. It sets pending, or it sets overrun if a character was already pending. A character flagged as a break is stored as 0.
- R6: `rd_data` presents the held character in bits 23:16, overrun in bit 15, LINE_ID in bits 4:0 and zero elsewhere. A read strobe clears pending and overrun.
- R7: In mode A, an enabling write has bit 13 set. A write with bit 13 clear disables the line and its receiver, so later characters are not accepted.
- R8: In mode B, a write with bit 13 set on a connected line does four things: it pulses `hangup` and `evt_coff`, clears all status, and cancels a transmission in progress. On an unconnected line it only clears line and receiver enable. In mode B, a write with bit 13 clear is the enabling write.
- R9: A rising `link_up` enables the receiver. In mode B, if the line was already enabled, it also sets carrier and DSR and pulses `evt_con`. Otherwise carrier stays clear.
- R10: In mode B, `skip_ok` is high when at least one condition is requested and every requested condition holds. The request bits are `skip_req[2]` for transmitter idle, `skip_req[1]` for carrier and `skip_req[0]` for DSR. In mode A, `skip_ok` equals transmitter idle.
- R11: A falling `link_up` clears line enable, transmit-interrupt enable, receiver enable, carrier, DSR, pending and overrun.
- R12: A read strobe and an accepted character in the same cycle leave the new character held with pending set and overrun clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_b | input | 1 | 0 = mode A, 1 = mode B |
| wr_valid | input | 1 | Host output word strobe |
| wr_word | input | 24 | Host output word |
| rd_strobe | input | 1 | Host receive read |
| rd_data | output | 24 | Receive read word |
| skip_req | input | 3 | Skip test condition select |
| skip_ok | output | 1 | Skip test result |
| link_up | input | 1 | Line connected level |
| rx_valid | input | 1 | Character arrival strobe |
| rx_char | input | 8 | Arriving character |
| rx_break | input | 1 | Arrival is a break |
| tx_out_valid | output | 1 | Transmitted character strobe |
| tx_out_char | output | 8 | Transmitted character |
| tx_busy | output | 1 | Transmit interval active |
| hangup | output | 1 | Hang-up pulse toward the line |
| line_en | output | 1 | Line enabled |
| xmit_ie | output | 1 | Transmit-interrupt enable |
| carrier | output | 1 | Carrier on |
| dsr | output | 1 | Data set ready |
| rx_pend | output | 1 | Character pending |
| rx_ovr | output | 1 | Receive overrun |
| evt_rx | output | 1 | Receive event pulse |
| evt_tx | output | 1 | Transmit event pulse |
| evt_con | output | 1 | Carrier-on event pulse |
| evt_coff | output | 1 | Carrier-off event pulse |

## Verification
The bench drives both modes through the same interpretations of bit 13. It sends enabling, disabling and hang-up words with transmit-interrupt enable both set and clear. This separates the mode decode from the transmit-event gating. Receive patterns cover these cases:
- single arrivals, which test pending
- back-to-back arrivals, which test overrun
- breaks, which test the zero substitution
- a read coinciding with an arrival, which tests R12's ordering

Connect and disconnect run on enabled and disabled lines, and skip requests are tried singly and in combination. These cases separate the carrier logic from receiver enable, and the all-conditions rule from an any-condition rule.

// File: rtl/lcs_pkg.sv
// Package: shared widths, host word field positions and the decoded command type
// for the line control and status unit. Assumes a 24-bit host word.
package lcs_pkg;
    localparam int WORD_W    = 24;
    localparam int CHAN_W    = 5;
    localparam int CHAR_W    = 8;
    localparam int CHAR_LSB  = 16;
    localparam int NOXMT_BIT = 15;
    localparam int XIE_BIT   = 14;
    localparam int CTRL_BIT  = 13;
    localparam int SKIP_W    = 3;
    localparam int SKIP_IDLE = 2;
    localparam int SKIP_CAR  = 1;
    localparam int SKIP_DSR  = 0;

    typedef struct packed {
        logic              enable;
        logic              disable_ln;
        logic              hangup;
        logic              load_tx;
        logic              xie;
        logic [CHAR_W-1:0] ch;
    } host_cmd_t;
endpackage

// File: rtl/lcs_cmd_decode.sv
// Module: lcs_cmd_decode
// Decodes one host output word into an enable, disable or hang-up command for
// this line. Assumes the word is valid for a single cycle; purely combinational.
module lcs_cmd_decode
    import lcs_pkg::*;
#(
    parameter int LINE_ID = 0
) (
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              mode_b,
    output host_cmd_t         cmd
);
    logic hit;
    logic ctrl;

    // Purpose: match the channel field and interpret the mode-dependent control bit.
    always_comb begin
        hit            = wr_valid && (wr_word[CHAN_W-1:0] == CHAN_W'(LINE_ID));
        ctrl           = wr_word[CTRL_BIT];
        cmd.ch         = wr_word[CHAR_LSB +: CHAR_W];
        cmd.xie        = wr_word[XIE_BIT];
        cmd.hangup     = hit && mode_b && ctrl;
        cmd.disable_ln = hit && !mode_b && !ctrl;
        cmd.enable     = hit && (mode_b ? !ctrl : ctrl);
        cmd.load_tx    = !wr_word[NOXMT_BIT];
    end
endmodule

// File: rtl/lcs_rx_buffer.sv
// Module: lcs_rx_buffer
// One-character receive holding register with pending and overrun flags.
// Assumes accept is already qualified by link and receiver enable.
module lcs_rx_buffer
    import lcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              accept,
    input  logic              rd,
    input  logic [CHAR_W-1:0] ch,
    input  logic              brk,
    output logic [CHAR_W-1:0] rbuf,
    output logic              pend,
    output logic              ovr,
    output logic              evt_rx
);
    logic still_pend;

    // Purpose: a read taking effect before an arrival in the same cycle.
    always_comb still_pend = pend && !rd;

    // Purpose: update holding register, flags and the receive event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbuf   <= '0;
            pend   <= 1'b0;
            ovr    <= 1'b0;
            evt_rx <= 1'b0;
        end else begin
            evt_rx <= accept && !clear;
            if (clear) begin
                pend <= 1'b0;
                ovr  <= 1'b0;
            end else if (accept) begin
                rbuf <= brk ? '0 : ch;
                pend <= 1'b1;
                ovr  <= still_pend ? 1'b1 : (ovr && !rd);
            end else if (rd) begin
                pend <= 1'b0;
                ovr  <= 1'b0;
            end
        end
    end

    assert_ovr_has_pend_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ovr |-> pend);
    assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !accept) |=> (!pend && !ovr));
    assert_read_and_arrive_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && accept && !clear) |=> (pend && !ovr));
endmodule

// File: rtl/lcs_tx_timer.sv
// Module: lcs_tx_timer
// Transmit holding register and busy interval of TX_CYCLES clocks standing in
// for serialisation. Assumes start and cancel are never high together.
module lcs_tx_timer
    import lcs_pkg::*;
#(
    parameter int TX_CYCLES = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cancel,
    input  logic [CHAR_W-1:0] ch,
    input  logic              link_up,
    output logic              busy,
    output logic              last,
    output logic              out_valid,
    output logic [CHAR_W-1:0] out_char
);
    localparam int CNT_W = $clog2(TX_CYCLES + 1);

    logic [CNT_W-1:0] cnt;

    // Purpose: derive busy and final-cycle indications from the counter.
    always_comb begin
        busy = (cnt != '0);
        last = (cnt == CNT_W'(1));
    end

    // Purpose: count down the busy interval and hold the character.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            out_char  <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= last && !cancel && link_up;
            if (start) out_char <= ch;
            if (cancel)              cnt <= '0;
            else if (start && !busy) cnt <= CNT_W'(TX_CYCLES);
            else if (busy)           cnt <= cnt - CNT_W'(1);
        end
    end

    assert_start_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    assert_busy_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last && !cancel) |=> busy);
    assert_done_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !busy || $past(start));
endmodule

// File: rtl/lcs_modem_status.sv
// Module: lcs_modem_status
// Line enable, transmit-interrupt enable, receiver enable, carrier and DSR, with
// connect, disconnect and hang-up handling and the status events. Assumes a
// disconnect outranks any host command in the same cycle.
module lcs_modem_status
    import lcs_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      mode_b,
    input  host_cmd_t cmd,
    input  logic      link_up,
    input  logic      tx_last,
    output logic      line_en,
    output logic      xie,
    output logic      rcv_en,
    output logic      carrier,
    output logic      dsr,
    output logic      evt_con,
    output logic      evt_coff,
    output logic      evt_tx,
    output logic      hangup,
    output logic      clear_rx,
    output logic      cancel_tx,
    output logic      start_tx
);
    logic link_q;
    logic link_rise;
    logic link_fall;
    logic en_n, xie_n, rcv_n, car_n, dsr_n, con_n, coff_n, hang_n;

    // Purpose: detect connect and disconnect edges.
    always_comb begin
        link_rise = link_up && !link_q;
        link_fall = !link_up && link_q;
    end

    // Purpose: next status under the priority disconnect > host command > connect.
    always_comb begin
        en_n = line_en; xie_n = xie; rcv_n = rcv_en; car_n = carrier; dsr_n = dsr;
        con_n = 1'b0; coff_n = 1'b0; hang_n = 1'b0;
        clear_rx = 1'b0; cancel_tx = 1'b0; start_tx = 1'b0;
        if (link_fall) begin
            en_n = 1'b0; xie_n = 1'b0; rcv_n = 1'b0; car_n = 1'b0; dsr_n = 1'b0;
            clear_rx = 1'b1;
        end else begin
            if (cmd.hangup) begin
                en_n  = 1'b0;
                rcv_n = 1'b0;
                if (link_up) begin
                    xie_n = 1'b0; car_n = 1'b0; dsr_n = 1'b0;
                    hang_n = 1'b1; coff_n = 1'b1;
                    cancel_tx = 1'b1; clear_rx = 1'b1;
                end
            end else if (cmd.disable_ln) begin
                en_n  = 1'b0;
                rcv_n = 1'b0;
            end else if (cmd.enable) begin
                en_n     = 1'b1;
                rcv_n    = 1'b1;
                xie_n    = cmd.xie;
                start_tx = cmd.load_tx;
            end
            if (link_rise && !cmd.hangup) begin
                rcv_n = 1'b1;
                if (mode_b && line_en) begin
                    car_n = 1'b1; dsr_n = 1'b1; con_n = 1'b1;
                end
            end
        end
    end

    // Purpose: register status, events and the link level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_q  <= 1'b0;
            line_en <= 1'b0; xie <= 1'b0; rcv_en <= 1'b0;
            carrier <= 1'b0; dsr <= 1'b0;
            evt_con <= 1'b0; evt_coff <= 1'b0; evt_tx <= 1'b0; hangup <= 1'b0;
        end else begin
            link_q   <= link_up;
            line_en  <= en_n;
            xie      <= xie_n;
            rcv_en   <= rcv_n;
            carrier  <= car_n;
            dsr      <= dsr_n;
            evt_con  <= con_n;
            evt_coff <= coff_n;
            hangup   <= hang_n;
            evt_tx   <= tx_last && !cancel_tx && xie;
        end
    end

    assert_linkdrop_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        link_fall |=> (!line_en && !xie && !rcv_en && !carrier && !dsr));
    assert_hangup_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hangup |-> (!carrier && !line_en && !xie));
    assert_con_sets_modem_R9: assert property (@(posedge clk) disable iff (!rst_n)
        evt_con |-> (carrier && dsr && mode_b));
    assert_disable_mode_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.disable_ln && !link_fall) |=> !line_en);
endmodule

// File: rtl/line_ctl_unit.sv
// Module: line_ctl_unit
// Top of the per-line control and status unit: host word decode, receive
// holding register, transmit interval, modem status, skip test and read word.
// Assumes one host action of each kind per cycle and a synchronous environment.
module line_ctl_unit
    import lcs_pkg::*;
#(
    parameter int LINE_ID   = 0,
    parameter int TX_CYCLES = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_b,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              rd_strobe,
    output logic [WORD_W-1:0] rd_data,
    input  logic [SKIP_W-1:0] skip_req,
    output logic              skip_ok,
    input  logic              link_up,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_char,
    input  logic              rx_break,
    output logic              tx_out_valid,
    output logic [CHAR_W-1:0] tx_out_char,
    output logic              tx_busy,
    output logic              hangup,
    output logic              line_en,
    output logic              xmit_ie,
    output logic              carrier,
    output logic              dsr,
    output logic              rx_pend,
    output logic              rx_ovr,
    output logic              evt_rx,
    output logic              evt_tx,
    output logic              evt_con,
    output logic              evt_coff
);
    localparam int PAD_W = WORD_W - CHAR_W - 1 - CHAN_W;

    host_cmd_t         cmd;
    logic              rcv_en;
    logic              clear_rx;
    logic              cancel_tx;
    logic              start_tx;
    logic              tx_last;
    logic              rx_accept;
    logic [CHAR_W-1:0] rbuf;

    lcs_cmd_decode #(.LINE_ID(LINE_ID)) u_decode (
        .wr_valid (wr_valid),
        .wr_word  (wr_word),
        .mode_b   (mode_b),
        .cmd      (cmd)
    );

    lcs_modem_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_b    (mode_b),
        .cmd       (cmd),
        .link_up   (link_up),
        .tx_last   (tx_last),
        .line_en   (line_en),
        .xie       (xmit_ie),
        .rcv_en    (rcv_en),
        .carrier   (carrier),
        .dsr       (dsr),
        .evt_con   (evt_con),
        .evt_coff  (evt_coff),
        .evt_tx    (evt_tx),
        .hangup    (hangup),
        .clear_rx  (clear_rx),
        .cancel_tx (cancel_tx),
        .start_tx  (start_tx)
    );

    // Purpose: qualify an arriving character by link and receiver enable.
    always_comb rx_accept = rx_valid && link_up && rcv_en;

    lcs_rx_buffer u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (clear_rx),
        .accept (rx_accept),
        .rd     (rd_strobe),
        .ch     (rx_char),
        .brk    (rx_break),
        .rbuf   (rbuf),
        .pend   (rx_pend),
        .ovr    (rx_ovr),
        .evt_rx (evt_rx)
    );

    lcs_tx_timer #(.TX_CYCLES(TX_CYCLES)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_tx),
        .cancel    (cancel_tx),
        .ch        (cmd.ch),
        .link_up   (link_up),
        .busy      (tx_busy),
        .last      (tx_last),
        .out_valid (tx_out_valid),
        .out_char  (tx_out_char)
    );

    // Purpose: assemble the host receive word.
    always_comb rd_data = {rbuf, rx_ovr, {PAD_W{1'b0}}, CHAN_W'(LINE_ID)};

    // Purpose: answer the skip test per mode.
    always_comb begin
        if (mode_b)
            skip_ok = (skip_req != '0)
                   && (!skip_req[SKIP_IDLE] || !tx_busy)
                   && (!skip_req[SKIP_CAR]  || carrier)
                   && (!skip_req[SKIP_DSR]  || dsr);
        else
            skip_ok = !tx_busy;
    end

    assert_skip_needs_request_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_b && skip_req == '0) |-> !skip_ok);
    assert_foreign_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_word[CHAN_W-1:0] != CHAN_W'(LINE_ID) && !link_up && !$past(link_up)
         && !tx_busy) |=> $stable(line_en) && !tx_busy);
endmodule

// File: tb/line_ctl_unit_tb.sv
// Bench: behavioural reference model compared every cycle, plus directed checks.
module line_ctl_unit_tb;
    localparam int LID = 5;
    localparam int TXC = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_b = 1'b0;
    logic        wr_valid = 1'b0;
    logic [23:0] wr_word = '0;
    logic        rd_strobe = 1'b0;
    logic [23:0] rd_data;
    logic [2:0]  skip_req = '0;
    logic        skip_ok;
    logic        link_up = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_char = '0;
    logic        rx_break = 1'b0;
    logic        tx_out_valid;
    logic [7:0]  tx_out_char;
    logic        tx_busy, hangup, line_en, xmit_ie, carrier, dsr;
    logic        rx_pend, rx_ovr, evt_rx, evt_tx, evt_con, evt_coff;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    line_ctl_unit #(.LINE_ID(LID), .TX_CYCLES(TXC)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_b(mode_b), .wr_valid(wr_valid), .wr_word(wr_word),
        .rd_strobe(rd_strobe), .rd_data(rd_data), .skip_req(skip_req), .skip_ok(skip_ok),
        .link_up(link_up), .rx_valid(rx_valid), .rx_char(rx_char), .rx_break(rx_break),
        .tx_out_valid(tx_out_valid), .tx_out_char(tx_out_char), .tx_busy(tx_busy),
        .hangup(hangup), .line_en(line_en), .xmit_ie(xmit_ie), .carrier(carrier), .dsr(dsr),
        .rx_pend(rx_pend), .rx_ovr(rx_ovr), .evt_rx(evt_rx), .evt_tx(evt_tx),
        .evt_con(evt_con), .evt_coff(evt_coff)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // reference model state
    bit m_lq, m_en, m_xie, m_rcv, m_car, m_dsr, m_pend, m_ovr;
    bit m_con, m_coff, m_hang, m_erx, m_etx, m_txo;
    int m_cnt;
    int m_rbuf, m_xbuf;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_lq = 0; m_en = 0; m_xie = 0; m_rcv = 0; m_car = 0; m_dsr = 0;
            m_pend = 0; m_ovr = 0; m_con = 0; m_coff = 0; m_hang = 0;
            m_erx = 0; m_etx = 0; m_txo = 0; m_cnt = 0; m_rbuf = 0; m_xbuf = 0;
        end else begin
            bit fall, rise, hit, b13, hang, dis, ena, clr, cancel, start, acc, last;
            bit old_en, old_xie, old_rcv, old_pend;
            old_en = m_en; old_xie = m_xie; old_rcv = m_rcv; old_pend = m_pend;
            fall = !link_up && m_lq;
            rise = link_up && !m_lq;
            hit  = wr_valid && (wr_word[4:0] == LID);
            b13  = wr_word[13];
            hang = hit && mode_b && b13;
            dis  = hit && !mode_b && !b13;
            ena  = hit && (mode_b ? !b13 : b13);
            clr = 0; cancel = 0; start = 0;
            m_con = 0; m_coff = 0; m_hang = 0;
            if (fall) begin
                m_en = 0; m_xie = 0; m_rcv = 0; m_car = 0; m_dsr = 0; clr = 1;
            end else begin
                if (hang) begin
                    m_en = 0; m_rcv = 0;
                    if (link_up) begin
                        m_xie = 0; m_car = 0; m_dsr = 0; m_hang = 1; m_coff = 1;
                        cancel = 1; clr = 1;
                    end
                end else if (dis) begin
                    m_en = 0; m_rcv = 0;
                end else if (ena) begin
                    m_en = 1; m_rcv = 1; m_xie = wr_word[14]; start = !wr_word[15];
                end
                if (rise && !hang) begin
                    m_rcv = 1;
                    if (mode_b && old_en) begin m_car = 1; m_dsr = 1; m_con = 1; end
                end
            end
            acc = rx_valid && link_up && old_rcv && !clr;
            m_erx = acc;
            if (clr) begin m_pend = 0; m_ovr = 0; end
            else if (acc) begin
                m_rbuf = rx_break ? 0 : int'(rx_char);
                m_ovr  = (old_pend && !rd_strobe) ? 1'b1 : (m_ovr && !rd_strobe);
                m_pend = 1;
            end else if (rd_strobe) begin m_pend = 0; m_ovr = 0; end
            last  = (m_cnt == 1);
            m_txo = last && !cancel && link_up;
            m_etx = last && !cancel && old_xie;
            if (start) m_xbuf = int'(wr_word[23:16]);
            if (cancel) m_cnt = 0;
            else if (start && m_cnt == 0) m_cnt = TXC;
            else if (m_cnt > 0) m_cnt = m_cnt - 1;
            m_lq = link_up;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit exp_skip;
            if (mode_b)
                exp_skip = (skip_req != 0) && (!skip_req[2] || m_cnt == 0)
                        && (!skip_req[1] || m_car) && (!skip_req[0] || m_dsr);
            else
                exp_skip = (m_cnt == 0);
            chk("R3 line_en",      32'(line_en), 32'(m_en));
            chk("R3 xmit_ie",      32'(xmit_ie), 32'(m_xie));
            chk("R3 tx_busy",      32'(tx_busy), 32'(m_cnt != 0));
            chk("R4 tx_out_valid", 32'(tx_out_valid), 32'(m_txo));
            chk("R4 evt_tx",       32'(evt_tx), 32'(m_etx));
            if (m_txo) chk("R4 tx_out_char", 32'(tx_out_char), 32'(m_xbuf));
            chk("R5 rx_pend",      32'(rx_pend), 32'(m_pend));
            chk("R5 rx_ovr",       32'(rx_ovr), 32'(m_ovr));
            chk("R5 evt_rx",       32'(evt_rx), 32'(m_erx));
            chk("R6 rd_data",      32'(rd_data), (m_rbuf << 16) | (32'(m_ovr) << 15) | LID);
            chk("R8 hangup",       32'(hangup), 32'(m_hang));
            chk("R8 evt_coff",     32'(evt_coff), 32'(m_coff));
            chk("R9 carrier",      32'(carrier), 32'(m_car));
            chk("R9 dsr",          32'(dsr), 32'(m_dsr));
            chk("R9 evt_con",      32'(evt_con), 32'(m_con));
            chk("R10 skip_ok",     32'(skip_ok), 32'(exp_skip));
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
        wr_valid = 0; rx_valid = 0; rd_strobe = 0; rx_break = 0;
    endtask

    function automatic logic [23:0] mkw(input int chn, input int c, input bit nox,
                                        input bit xi, input bit b13);
        return {8'(c), nox, xi, b13, 8'b0, 5'(chn)};
    endfunction

    task automatic host_write(input logic [23:0] w);
        wr_word = w; wr_valid = 1; tick();
    endtask

    task automatic arrive(input int c, input bit brk);
        rx_char = 8'(c); rx_break = brk; rx_valid = 1; tick();
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog expired (all requirements)");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1; tick();
        // R1 reset state
        chk("R1 line_en", 32'(line_en), 0);
        chk("R1 status",  32'({xmit_ie, carrier, dsr, rx_pend, rx_ovr, tx_busy}), 0);
        chk("R1 events",  32'({evt_rx, evt_tx, evt_con, evt_coff, hangup}), 0);

        // R2 foreign channel ignored
        host_write(mkw(7, 8'h55, 0, 1, 1));
        chk("R2 line_en", 32'(line_en), 0);
        chk("R2 tx_busy", 32'(tx_busy), 0);

        // R3/R4 mode A enable with transmit and interrupt
        host_write(mkw(LID, 8'h41, 0, 1, 1));
        chk("R3 line_en", 32'(line_en), 1);
        chk("R3 busy", 32'(tx_busy), 1);
        repeat (TXC - 1) tick();
        chk("R3 busy at end", 32'(tx_busy), 1);
        tick();
        chk("R4 out_valid", 32'(tx_out_valid), 0); // link down: no char out
        chk("R4 evt_tx", 32'(evt_tx), 1);

        // connect in mode A; no carrier
        link_up = 1; tick();
        chk("R9 mode A no carrier", 32'(carrier), 0);

        // R4 no interrupt when xie clear; write while busy keeps interval
        host_write(mkw(LID, 8'h42, 0, 0, 1));
        tick();
        host_write(mkw(LID, 8'h43, 0, 0, 1));
        repeat (TXC - 2) tick();
        chk("R3 not restarted", 32'(tx_out_valid), 1);
        chk("R4 char", 32'(tx_out_char), 32'h43);
        chk("R4 no evt_tx", 32'(evt_tx), 0);

        // R5 receive, overrun, break; R6 read
        arrive(8'h31, 0);
        chk("R5 pend", 32'(rx_pend), 1);
        arrive(8'h32, 0);
        chk("R5 ovr", 32'(rx_ovr), 1);
        chk("R6 rd_data", 32'(rd_data), 32'h328005);
        rd_strobe = 1; tick();
        chk("R6 cleared", 32'({rx_pend, rx_ovr}), 0);
        arrive(8'h77, 1);
        chk("R5 break zero", 32'(rd_data[23:16]), 0);
        // R12 read with arrival
        rd_strobe = 1; rx_char = 8'h5A; rx_valid = 1; tick();
        chk("R12 pend", 32'(rx_pend), 1);
        chk("R12 ovr", 32'(rx_ovr), 0);
        chk("R12 char", 32'(rd_data[23:16]), 32'h5A);
        rd_strobe = 1; tick();

        // R10 mode A skip follows idle
        skip_req = 3'b000;
        host_write(mkw(LID, 8'h20, 0, 1, 1));
        chk("R10 mode A busy", 32'(skip_ok), 0);
        repeat (TXC) tick();
        chk("R10 mode A idle", 32'(skip_ok), 1);

        // R7 disable in mode A blocks receive
        host_write(mkw(LID, 0, 1, 0, 0));
        chk("R7 line_en", 32'(line_en), 0);
        arrive(8'h61, 0);
        chk("R7 rejected", 32'(rx_pend), 0);

        // R11 disconnect clears status
        host_write(mkw(LID, 0, 1, 1, 1));
        arrive(8'h62, 0);
        link_up = 0; tick();
        chk("R11 cleared", 32'({line_en, xmit_ie, rx_pend, rx_ovr}), 0);

        // mode B: R9 connect on enabled line
        mode_b = 1;
        host_write(mkw(LID, 0, 1, 1, 0));
        chk("R8 mode B enable", 32'(line_en), 1);
        link_up = 1; tick();
        chk("R9 carrier dsr", 32'({carrier, dsr}), 2'b11);
        chk("R9 evt_con", 32'(evt_con), 1);
        // R10 combinations
        skip_req = 3'b011; #1 chk("R10 car+dsr", 32'(skip_ok), 1);
        skip_req = 3'b000; #1 chk("R10 none", 32'(skip_ok), 0);
        host_write(mkw(LID, 8'h44, 0, 1, 0));
        skip_req = 3'b110; #1 chk("R10 idle fails", 32'(skip_ok), 0);
        skip_req = 3'b010; #1 chk("R10 carrier only", 32'(skip_ok), 1);
        tick();
        // R8 hangup while connected and busy
        arrive(8'h33, 0);
        host_write(mkw(LID, 0, 1, 0, 1));
        chk("R8 hangup", 32'(hangup), 1);
        chk("R8 evt_coff", 32'(evt_coff), 1);
        chk("R8 cleared", 32'({line_en, carrier, dsr, tx_busy, rx_pend}), 0);
        link_up = 0; tick();
        repeat (TXC) tick();
        chk("R8 no tx out", 32'(tx_out_valid), 0);

        // R8 hangup on unconnected line; R9 connect on disabled line
        host_write(mkw(LID, 0, 1, 1, 0));
        host_write(mkw(LID, 0, 1, 1, 1));
        chk("R8 unconnected hangup", 32'({line_en, hangup, evt_coff}), 0);
        chk("R8 xie kept", 32'(xmit_ie), 1);
        link_up = 1; tick();
        chk("R9 disabled no carrier", 32'({carrier, evt_con}), 0);
        arrive(8'h34, 0);
        chk("R9 receiver enabled by connect", 32'(rx_pend), 1);
        repeat (3) tick();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule